// File: doc/BRIEF.md
# First/Next Error Logging Unit

This block gathers error events from one interface unit and keeps a record of them for software. Three event sources arrive at its inputs. A received correctable-error message comes as a one-cycle pulse with a source identifier. A parity error on data from the core comes as a one-cycle pulse. Link loss is derived inside the block from a link-status level. Each event has a fixed class. The earliest logged event is held in a first-error register. Later occurrences are collected in a next-error register that holds one sticky bit per event type.

A mask register suppresses an event entirely: it is neither logged nor reported. Four routing registers choose, per event, which of four level notification outputs it drives. The outputs are a system-control interrupt, a system-management interrupt, a system error and a machine-check error. The system error output also needs a global command enable. Two summary flags show whether any fatal or any non-fatal error is logged. Software reaches all registers through one address with a combinational read and a write strobe. The two log registers clear when a 1 is written to a bit.

Top module: `errLogUnit`

## Requirements
- R1: After reset the mask, the four routing registers, the command enable, both log registers and the source identifier read 0, and all six outputs are low.
- R2: Event bit positions are 0 = correctable message (non-fatal class), 1 = core data parity (uncorrectable, non-fatal), 2 = link loss (uncorrectable, fatal). `globalFatal` is high while bit 2 is logged and unmasked. `globalNonFatal` is high while bit 0 or bit 1 is logged and unmasked.
- R3: A link-loss event is produced only on a cycle where `linkUp` goes from 1 to 0. It is not produced while the link stays down.
- R4: While the first-error register (address 6) is nonzero, new events do not change it. The source identifier (address 8) is captured only when a correctable message becomes the first error.
- R5: An unmasked event that does not become the first error sets its bit in the next-error register (address 7). That bit stays set until it is cleared.
- R6: When several unmasked events arrive in the same cycle and the first-error register is empty, the first-error register takes the link loss over the parity error, and the parity error over the correctable message. The remaining events go into the next-error register.
- R7: A set bit in the mask register (address 0) stops that event from being logged. It also removes an already-logged bit of that event from every output.
- R8: Routing registers at addresses 1 (SCI), 2 (SMI), 3 (SERR) and 4 (MCERR) hold one enable bit per event position. An output is high while a logged, unmasked event whose enable bit is set in its routing register is present.
- R9: `serrOut` additionally requires bit 0 of the command register (address 5) to be 1.
- R10: Writing 1s to address 6 or 7 clears those bits. Once the first-error register is empty, the next unmasked event becomes the new first error.
- R11: Outputs are levels: they stay high for as long as the causing log bit stays set, and fall in the cycle after it is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| corMsgValid | input | 1 | One-cycle pulse: correctable error message received |
| corMsgSrcId | input | SRCID_W | Source identifier of that message |
| parityErr | input | 1 | One-cycle pulse: parity error on core data |
| linkUp | input | 1 | Link status level, 1 = up |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | ADDR_W | Register address for read and write |
| regWrData | input | EVT_N | Write data (one bit per event position, bit 0 for the command enable) |
| regRdData | output | DATA_W | Combinational read data at `regAddr` |
| sciOut | output | 1 | System-control interrupt level |
| smiOut | output | 1 | System-management interrupt level |
| serrOut | output | 1 | System error level |
| mcerrOut | output | 1 | Machine-check error level |
| globalFatal | output | 1 | A fatal error is logged |
| globalNonFatal | output | 1 | A non-fatal error is logged |

## Verification
A wrong log state is visible one cycle after the event's clock edge: it shows at the read port and in the notification and summary levels. A wrong priority choice shows up as the wrong one-hot code at address 6 together with the missing bit at address 7. A false link-loss event while the link stays down shows as a next-error bit that comes back right after a clear. A stale or lost source identifier shows only when address 8 is read, so it is read both after a correctable first error and after a correctable event that was not first.

// File: rtl/errlog_pkg.sv
package errlog_pkg;
  localparam int EVT_N   = 3;
  localparam int EVT_COR = 0;
  localparam int EVT_PAR = 1;
  localparam int EVT_LNK = 2;
  localparam int ADDR_W  = 4;
  localparam int CFG_N   = 6;
  localparam int ROUTE_N = 4;

  localparam logic [EVT_N-1:0] FATAL_SET = 3'b100;

  localparam logic [ADDR_W-1:0] A_MASK  = 4'd0;
  localparam logic [ADDR_W-1:0] A_SCI   = 4'd1;
  localparam logic [ADDR_W-1:0] A_SMI   = 4'd2;
  localparam logic [ADDR_W-1:0] A_SERR  = 4'd3;
  localparam logic [ADDR_W-1:0] A_MCERR = 4'd4;
  localparam logic [ADDR_W-1:0] A_CMD   = 4'd5;
  localparam logic [ADDR_W-1:0] A_FIRST = 4'd6;
  localparam logic [ADDR_W-1:0] A_NEXT  = 4'd7;
  localparam logic [ADDR_W-1:0] A_SRCID = 4'd8;

  typedef struct packed {
    logic [EVT_N-1:0] firstSet;
    logic [EVT_N-1:0] nextSet;
    logic [EVT_N-1:0] firstClr;
    logic [EVT_N-1:0] nextClr;
    logic             srcCapture;
    logic [CFG_N-1:0] cfgWr;
  } logStrobe_t;
endpackage

// File: rtl/errLogCtrl.sv
module errLogCtrl
  import errlog_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              corMsgValid,
  input  logic              parityErr,
  input  logic              linkUp,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [EVT_N-1:0]  regWrData,
  input  logic [EVT_N-1:0]  maskVec,
  input  logic [EVT_N-1:0]  firstLog,
  output logStrobe_t        strobes
);
  logic             linkUpQ;
  logic             linkFall;
  logic [EVT_N-1:0] evtRaw;
  logic [EVT_N-1:0] evtLive;
  logic [EVT_N-1:0] pick;
  logic [EVT_N-1:0] firstClrV;
  logic [EVT_N-1:0] nextClrV;
  logic             firstFree;

  always_ff @(posedge clk) begin
    if (!rstN) linkUpQ <= 1'b0;
    else       linkUpQ <= linkUp;
  end

  assign linkFall = linkUpQ & ~linkUp;

  always_comb begin
    evtRaw          = '0;
    evtRaw[EVT_COR] = corMsgValid;
    evtRaw[EVT_PAR] = parityErr;
    evtRaw[EVT_LNK] = linkFall;
  end

  assign evtLive = evtRaw & ~maskVec;

  // highest event index wins: fatal, then non-fatal, then correctable
  always_comb begin
    logic found;
    pick  = '0;
    found = 1'b0;
    for (int i = EVT_N - 1; i >= 0; i--) begin
      if (evtLive[i] && !found) begin
        pick[i] = 1'b1;
        found   = 1'b1;
      end
    end
  end

  assign firstClrV = (regWrEn && regAddr == A_FIRST) ? regWrData : '0;
  assign nextClrV  = (regWrEn && regAddr == A_NEXT)  ? regWrData : '0;
  assign firstFree = ((firstLog & ~firstClrV) == '0);

  always_comb begin
    strobes.firstClr   = firstClrV;
    strobes.nextClr    = nextClrV;
    strobes.firstSet   = firstFree ? pick : '0;
    strobes.nextSet    = evtLive & ~strobes.firstSet;
    strobes.srcCapture = strobes.firstSet[EVT_COR];
  end

  for (genvar c = 0; c < CFG_N; c++) begin : g_cfgWr
    assign strobes.cfgWr[c] = regWrEn && (regAddr == ADDR_W'(c));
  end

  // R6
  prio_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.firstSet[EVT_COR] |-> !evtLive[EVT_PAR] && !evtLive[EVT_LNK]);

  // R3
  link_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
    evtRaw[EVT_LNK] |-> $fell(linkUp));

  // R7
  mask_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((strobes.firstSet | strobes.nextSet) & maskVec) == '0);
endmodule

// File: rtl/errLogData.sv
module errLogData
  import errlog_pkg::*;
#(
  parameter int SRCID_W = 16,
  parameter int DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logStrobe_t         strobes,
  input  logic [EVT_N-1:0]   regWrData,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [SRCID_W-1:0] corMsgSrcId,
  output logic [DATA_W-1:0]  regRdData,
  output logic [EVT_N-1:0]   maskVec,
  output logic [EVT_N-1:0]   firstLog,
  output logic [ROUTE_N-1:0] notify,
  output logic               fatalAny,
  output logic               nonFatalAny
);
  logic [EVT_N-1:0]   maskReg;
  logic [EVT_N-1:0]   routeReg [ROUTE_N];
  logic               serrGlobalEn;
  logic [EVT_N-1:0]   nextLog;
  logic [SRCID_W-1:0] srcIdReg;
  logic [EVT_N-1:0]   activeVec;
  logic [ROUTE_N-1:0] routeHit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      maskReg      <= '0;
      serrGlobalEn <= 1'b0;
      firstLog     <= '0;
      nextLog      <= '0;
      srcIdReg     <= '0;
    end else begin
      if (strobes.cfgWr[int'(A_MASK)]) maskReg      <= regWrData;
      if (strobes.cfgWr[int'(A_CMD)])  serrGlobalEn <= regWrData[0];
      firstLog <= (firstLog & ~strobes.firstClr) | strobes.firstSet;
      nextLog  <= (nextLog  & ~strobes.nextClr)  | strobes.nextSet;
      if (strobes.srcCapture) srcIdReg <= corMsgSrcId;
    end
  end

  for (genvar r = 0; r < ROUTE_N; r++) begin : g_route
    always_ff @(posedge clk) begin
      if (!rstN)                                  routeReg[r] <= '0;
      else if (strobes.cfgWr[int'(A_SCI) + r])    routeReg[r] <= regWrData;
    end
    assign routeHit[r] = |(activeVec & routeReg[r]);
  end

  assign maskVec   = maskReg;
  assign activeVec = (firstLog | nextLog) & ~maskReg;

  always_comb begin
    notify               = routeHit;
    notify[int'(A_SERR) - int'(A_SCI)] = routeHit[int'(A_SERR) - int'(A_SCI)] & serrGlobalEn;
  end

  assign fatalAny    = |(activeVec & FATAL_SET);
  assign nonFatalAny = |(activeVec & ~FATAL_SET);

  always_comb begin
    regRdData = '0;
    case (regAddr)
      A_MASK:  regRdData[EVT_N-1:0]   = maskReg;
      A_SCI:   regRdData[EVT_N-1:0]   = routeReg[0];
      A_SMI:   regRdData[EVT_N-1:0]   = routeReg[1];
      A_SERR:  regRdData[EVT_N-1:0]   = routeReg[2];
      A_MCERR: regRdData[EVT_N-1:0]   = routeReg[3];
      A_CMD:   regRdData[0]           = serrGlobalEn;
      A_FIRST: regRdData[EVT_N-1:0]   = firstLog;
      A_NEXT:  regRdData[EVT_N-1:0]   = nextLog;
      A_SRCID: regRdData[SRCID_W-1:0] = srcIdReg;
      default: regRdData = '0;
    endcase
  end

  // R4
  first_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (firstLog != '0 && strobes.firstClr == '0) |=> firstLog == $past(firstLog));

  // R4
  first_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(firstLog));

  // R5
  next_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.nextClr == '0 |=> (nextLog & $past(nextLog)) == $past(nextLog));

  // R9
  serr_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    !serrGlobalEn |-> !notify[int'(A_SERR) - int'(A_SCI)]);
endmodule

// File: rtl/errLogUnit.sv
module errLogUnit
  import errlog_pkg::*;
#(
  parameter int SRCID_W = 16,
  parameter int DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               corMsgValid,
  input  logic [SRCID_W-1:0] corMsgSrcId,
  input  logic               parityErr,
  input  logic               linkUp,
  input  logic               regWrEn,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [EVT_N-1:0]   regWrData,
  output logic [DATA_W-1:0]  regRdData,
  output logic               sciOut,
  output logic               smiOut,
  output logic               serrOut,
  output logic               mcerrOut,
  output logic               globalFatal,
  output logic               globalNonFatal
);
  logStrobe_t         strobes;
  logic [EVT_N-1:0]   maskVec;
  logic [EVT_N-1:0]   firstLog;
  logic [ROUTE_N-1:0] notify;

  errLogCtrl uCtrl (
    .clk         (clk),
    .rstN        (rstN),
    .corMsgValid (corMsgValid),
    .parityErr   (parityErr),
    .linkUp      (linkUp),
    .regWrEn     (regWrEn),
    .regAddr     (regAddr),
    .regWrData   (regWrData),
    .maskVec     (maskVec),
    .firstLog    (firstLog),
    .strobes     (strobes)
  );

  errLogData #(.SRCID_W(SRCID_W), .DATA_W(DATA_W)) uData (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .regWrData   (regWrData),
    .regAddr     (regAddr),
    .corMsgSrcId (corMsgSrcId),
    .regRdData   (regRdData),
    .maskVec     (maskVec),
    .firstLog    (firstLog),
    .notify      (notify),
    .fatalAny    (globalFatal),
    .nonFatalAny (globalNonFatal)
  );

  assign sciOut   = notify[0];
  assign smiOut   = notify[1];
  assign serrOut  = notify[2];
  assign mcerrOut = notify[3];
endmodule

// File: tb/tb_errLogUnit.sv
`timescale 1ns/1ps
module tb_errLogUnit;
  logic        clk = 1'b0;
  logic        rstN;
  logic        corMsgValid;
  logic [15:0] corMsgSrcId;
  logic        parityErr;
  logic        linkUp;
  logic        regWrEn;
  logic [3:0]  regAddr;
  logic [2:0]  regWrData;
  logic [31:0] regRdData;
  logic        sciOut, smiOut, serrOut, mcerrOut, globalFatal, globalNonFatal;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  typedef struct {
    logic [31:0] rd;
    logic [5:0]  outs;
    string       tag;
  } item_t;
  item_t sbQ[$];

  always #2 clk = ~clk;

  errLogUnit dut (
    .clk(clk), .rstN(rstN), .corMsgValid(corMsgValid), .corMsgSrcId(corMsgSrcId),
    .parityErr(parityErr), .linkUp(linkUp), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .sciOut(sciOut), .smiOut(smiOut),
    .serrOut(serrOut), .mcerrOut(mcerrOut), .globalFatal(globalFatal),
    .globalNonFatal(globalNonFatal)
  );

  // driver: one cycle of stimulus, applied at the falling edge
  task automatic drive(input logic cor, input logic [15:0] sid, input logic par,
                       input logic lk, input logic we, input logic [3:0] addr,
                       input logic [2:0] wd);
    @(negedge clk);
    corMsgValid = cor; corMsgSrcId = sid; parityErr = par; linkUp = lk;
    regWrEn = we; regAddr = addr; regWrData = wd;
  endtask

  // expected state just after the coming rising edge; outs = {sci,smi,serr,mcerr,fatal,nonfatal}
  task automatic expectAfter(input logic [31:0] rd, input logic [5:0] o, input string tag);
    item_t it;
    it.rd = rd; it.outs = o; it.tag = tag;
    sbQ.push_back(it);
  endtask

  // monitor: compares 1 ns after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sbQ.size() > 0) begin
        item_t it;
        logic [5:0] act;
        it  = sbQ.pop_front();
        act = {sciOut, smiOut, serrOut, mcerrOut, globalFatal, globalNonFatal};
        checks++;
        if (regRdData !== it.rd || act !== it.outs) begin
          errors++;
          $display("FAIL %s: rd=%h outs=%b expected rd=%h outs=%b",
                   it.tag, regRdData, act, it.rd, it.outs);
        end
      end
    end
  end

  initial begin
    #400000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0;
    corMsgValid = 0; corMsgSrcId = '0; parityErr = 0; linkUp = 1;
    regWrEn = 0; regAddr = 4'd6; regWrData = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    drive(0, 16'h0, 0, 1, 0, 4'd6, 3'd0); expectAfter(32'h0, 6'b000000, "R1 first after reset");
    drive(0, 16'h0, 0, 1, 0, 4'd8, 3'd0); expectAfter(32'h0, 6'b000000, "R1 srcid after reset");

    // routing setup: sci=cor, smi=par, serr=link, mcerr=par|link
    drive(0, 16'h0, 0, 1, 1, 4'd1, 3'b001); expectAfter(32'h1, 6'b000000, "R8 sci route write");
    drive(0, 16'h0, 0, 1, 1, 4'd2, 3'b010);
    drive(0, 16'h0, 0, 1, 1, 4'd3, 3'b100);
    drive(0, 16'h0, 0, 1, 1, 4'd4, 3'b110); expectAfter(32'h6, 6'b000000, "R8 mcerr route write");

    // R2 R8 parity becomes first error
    drive(0, 16'h0, 1, 1, 0, 4'd6, 3'd0); expectAfter(32'h2, 6'b010101, "R2 parity first");
    // R5 correctable goes to next log
    drive(1, 16'hBEEF, 0, 1, 0, 4'd7, 3'd0); expectAfter(32'h1, 6'b110101, "R5 correctable in next");
    // R4 no capture of srcid when not first
    drive(0, 16'h0, 0, 1, 0, 4'd8, 3'd0); expectAfter(32'h0, 6'b110101, "R4 srcid not captured");
    drive(1, 16'h1111, 0, 1, 0, 4'd6, 3'd0); expectAfter(32'h2, 6'b110101, "R4 first holds");
    // R3 R9 link loss, serr blocked without command enable
    drive(0, 16'h0, 0, 0, 0, 4'd7, 3'd0); expectAfter(32'h5, 6'b110111, "R9 link loss serr gated");
    // R10 clear next log
    drive(0, 16'h0, 0, 0, 1, 4'd7, 3'b111); expectAfter(32'h0, 6'b010101, "R10 clear next");
    // R3 link stays down: no new event
    drive(0, 16'h0, 0, 0, 0, 4'd7, 3'd0); expectAfter(32'h0, 6'b010101, "R3 no event while down");
    drive(0, 16'h0, 0, 0, 1, 4'd5, 3'b001); expectAfter(32'h1, 6'b010101, "R9 command enable set");
    // R11 clearing the first error drops all outputs
    drive(0, 16'h0, 0, 0, 1, 4'd6, 3'b010); expectAfter(32'h0, 6'b000000, "R11 outputs fall after clear");
    drive(0, 16'h0, 0, 1, 0, 4'd6, 3'd0); expectAfter(32'h0, 6'b000000, "R3 link rise no event");

    // R6 simultaneous events
    drive(1, 16'h1234, 1, 0, 0, 4'd6, 3'd0); expectAfter(32'h4, 6'b111111, "R6 link wins first");
    drive(0, 16'h0, 0, 0, 0, 4'd7, 3'd0); expectAfter(32'h3, 6'b111111, "R6 others in next");
    drive(0, 16'h0, 0, 0, 0, 4'd8, 3'd0); expectAfter(32'h0, 6'b111111, "R4 srcid when cor not first");
    drive(0, 16'h0, 0, 0, 1, 4'd6, 3'b111); expectAfter(32'h0, 6'b110101, "R10 clear first keeps next");
    drive(0, 16'h0, 0, 0, 1, 4'd7, 3'b111); expectAfter(32'h0, 6'b000000, "R10 clear next all low");
    drive(0, 16'h0, 0, 1, 0, 4'd6, 3'd0);

    // R10 new first after clear, R4 capture
    drive(1, 16'h1234, 0, 1, 0, 4'd8, 3'd0); expectAfter(32'h1234, 6'b100001, "R4 R10 new first srcid");
    drive(0, 16'h0, 0, 1, 0, 4'd6, 3'd0); expectAfter(32'h1, 6'b100001, "R11 level held");
    // R7 mask hides logged bit and blocks new logging
    drive(0, 16'h0, 0, 1, 1, 4'd0, 3'b001); expectAfter(32'h1, 6'b000000, "R7 mask hides output");
    drive(0, 16'h0, 0, 1, 1, 4'd0, 3'b010); expectAfter(32'h2, 6'b100001, "R7 unmask restores");
    drive(0, 16'h0, 1, 1, 0, 4'd7, 3'd0); expectAfter(32'h0, 6'b100001, "R7 masked parity not logged");
    drive(0, 16'h0, 0, 1, 0, 4'd6, 3'd0); expectAfter(32'h1, 6'b100001, "R7 first unchanged");

    drive(0, 16'h0, 0, 1, 0, 4'd6, 3'd0);
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule